// File: doc/BRIEF.md
# Packed-Lane Wide Accumulator with Rounding Readout

This block keeps a bank of wide signed accumulators for packed 64-bit SIMD data. The bank can be viewed in two ways. In byte format it is eight 24-bit lanes, and each lane is fed by unsigned bytes. In halfword format it is four 48-bit lanes, and each lane is fed by signed halfwords. One command per clock can do any of the following:

- update every lane with a sum, difference, product or absolute difference of two packed operands, either added to the lane or loaded into it;
- read or write one 8-bit or 16-bit slice of every lane;
- produce a packed 64-bit readout, in which each lane is shifted right, rounded and saturated.

The second operand is either a full vector, or its lane 0 broadcast to all lanes. For a rounding readout, the same operand carries the per-lane shift amounts.

The command code is 0 idle, 1 accumulate, 2 raw read, 3 write-low, 4 write-high and 5 round. Codes 6 and 7 act as idle. The `code` input holds the accumulate op, the read slice or the rounding mode. `half` selects halfword format and `bcast` selects the broadcast operand. The result and the error flag are registered, and they change only on a raw read or a round command.

Top module: `lane_acc_round`

## Requirements
- R1: After reset every accumulator bit is zero, `res` is zero and `err` is low; a raw read of any slice right after reset returns zero.
- R2: Byte-format accumulate (x = opa byte, y = second-operand byte, both unsigned, result modulo 2^24) uses these codes: 0 acc+x+y, 1 x+y, 2 acc+x*y, 3 x*y, 4 acc-x*y, 5 -(x*y), 6 acc+x-y, 7 x-y, 8 acc+|x-y|. Codes 9 to 15 leave the accumulators unchanged.
- R3: Halfword-format accumulate uses the same codes 0 to 7, but on signed halfwords with results modulo 2^48. Codes 8 to 15 leave the accumulators unchanged.
- R4: With `bcast`=1, every lane uses the second-operand lane 0 (bits [7:0] in byte format, [15:0] in halfword format) in place of its own lane, both for accumulation and for shift amounts.
- R5: A raw read with slice code s returns a packed result with lane 0 in the least significant position. For s = 0, 1 or 2 the result holds bits [16s+15:16s] of each halfword accumulator, or bits [8s+7:8s] of each byte accumulator. Codes 3 to 15 return zero. A raw read clears `err`.
- R6: Write-low sets each lane as follows:
  - the opa lane, sign-extended, goes into the middle slice and everything above it;
  - the opb lane goes into the low slice.

  Write-high replaces only the top slice (bits [47:32] or [23:16]) with the opa lane.
- R7: Rounding mode codes are 0 nearest-away signed, 1 nearest-away unsigned, 2 nearest-even signed, 3 nearest-even unsigned, 4 truncate signed and 5 truncate unsigned. A nearest mode adds one when the bit just below the shift point is set. Nearest-even on an exact tie adds one only when the shifted value is odd. Signed nearest-away on a negative accumulator adds one only when the discarded bits exceed one half.
- R8: Signed results saturate to -32768..32767. Unsigned results saturate to 0xFFFF for halfwords and 0xFF for bytes.
- R9: Large shifts give zero in these cases:
  - nearest-away signed above 48;
  - the other signed modes at 48 or more;
  - unsigned modes above the lane width (48 or 24).

  An unsigned nearest-away shift equal to the width returns the accumulator's top bit.
- R10: In halfword format a negative shift amount (bit 15 set) forces that lane's result to zero and raises `err`.
- R11: In a round command, a mode code above 5, or a signed mode (0, 2, 4) in byte format, gives an all-zero result and raises `err`.
- R12: `res` and `err` are updated one clock after a raw read or round command. Every other command code leaves them unchanged.
- R13: Both formats share the same 192 accumulator bits. Halfword lane i is bits [48i+47:48i] and byte lane j is bits [24j+23:24j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code |
| code | input | 4 | Accumulate op, read slice or rounding mode |
| half | input | 1 | 1 selects halfword format, 0 byte format |
| bcast | input | 1 | 1 broadcasts second-operand lane 0 |
| opa | input | 64 | First packed operand |
| opb | input | 64 | Second packed operand or shift amounts |
| res | output | 64 | Registered packed result |
| err | output | 1 | Registered error flag of the last read or round |

## Verification
The bench builds the block with its default of eight byte lanes, which gives four halfword lanes over a shared 192-bit store. At that size, a few directed commands reach every rounding boundary the requirements name: shifts of 0, 1, 24, 25, 47, 48 and 49. The same is true of saturation from both ends and of the reinterpretation of byte lanes as halfword lanes. Random mixes of commands, formats, broadcast settings and shift amounts, including negative and oversized ones, then compare every readout against bench functions.

// File: rtl/lane_acc_round.sv
module lane_acc_round #(
  parameter int NB = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cmd,
  input  logic [3:0]     code,
  input  logic           half,
  input  logic           bcast,
  input  logic [NB*8-1:0] opa,
  input  logic [NB*8-1:0] opb,
  output logic [NB*8-1:0] res,
  output logic           err
);
  localparam int DW = NB * 8;
  localparam int NH = NB / 2;
  localparam int AB = 24;
  localparam int AH = 48;
  localparam int AW = NB * AB;

  localparam logic [2:0] C_ACC = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WLO = 3'd3;
  localparam logic [2:0] C_WHI = 3'd4;
  localparam logic [2:0] C_RND = 3'd5;

  logic [AW-1:0] acc_q, acc_d;
  logic [DW-1:0] res_q, res_d;
  logic          err_q, err_d;

  function automatic logic [AH-1:0] hstep(logic [AH-1:0] a, logic [15:0] x,
                                          logic [15:0] y, logic [3:0] op);
    logic [AH-1:0] xs, ys, p, d;
    logic signed [31:0] p32;
    xs  = {{32{x[15]}}, x};
    ys  = {{32{y[15]}}, y};
    p32 = $signed(x) * $signed(y);
    p   = {{16{p32[31]}}, p32};
    d   = xs - ys;
    case (op)
      4'd0: return a + xs + ys;
      4'd1: return xs + ys;
      4'd2: return a + p;
      4'd3: return p;
      4'd4: return a - p;
      4'd5: return '0 - p;
      4'd6: return a + d;
      4'd7: return d;
      default: return a;
    endcase
  endfunction

  function automatic logic [AB-1:0] bstep(logic [AB-1:0] a, logic [7:0] x,
                                          logic [7:0] y, logic [3:0] op);
    logic [AB-1:0] xe, ye, p, d, ad;
    logic [15:0] p16;
    xe  = {16'b0, x};
    ye  = {16'b0, y};
    p16 = {8'b0, x} * {8'b0, y};
    p   = {8'b0, p16};
    d   = xe - ye;
    ad  = {16'b0, (x >= y) ? (x - y) : (y - x)};
    case (op)
      4'd0: return a + xe + ye;
      4'd1: return xe + ye;
      4'd2: return a + p;
      4'd3: return p;
      4'd4: return a - p;
      4'd5: return '0 - p;
      4'd6: return a + d;
      4'd7: return d;
      4'd8: return a + ad;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] rnd(logic [AH-1:0] a, logic hf,
                                      logic [6:0] s, logic [2:0] m);
    logic signed [AH+1:0] v, t, r;
    logic [AH+1:0] vu, msk, sh1;
    logic sg, g, st, inc, zero;
    sg  = (m == 3'd0) || (m == 3'd2) || (m == 3'd4);
    if (hf) v = sg ? {{2{a[AH-1]}}, a} : {2'b00, a};
    else    v = {{(AH+2-AB){1'b0}}, a[AB-1:0]};
    vu  = v;
    t   = v >>> s;
    sh1 = vu >> (s - 7'd1);
    g   = (s != 7'd0) && sh1[0];
    msk = (s > 7'd1) ? ((AH'(1) << (s - 7'd1)) - 1'b1) : '0;
    st  = |(vu & msk);
    case (m)
      3'd0:       inc = v[AH+1] ? (g && st) : g;
      3'd1:       inc = g;
      3'd2, 3'd3: inc = g && (st || t[0]);
      default:    inc = 1'b0;
    endcase
    r = t + (inc ? 50'sd1 : 50'sd0);
    if (m == 3'd0)                  zero = s > 7'd48;
    else if (m == 3'd2 || m == 3'd4) zero = s >= 7'd48;
    else                            zero = hf ? (s > 7'd48) : (s > 7'd24);
    if (zero) return 16'd0;
    if (sg) begin
      if (r > 50'sd32767)  return 16'h7FFF;
      if (r < -50'sd32768) return 16'h8000;
      return r[15:0];
    end
    if (hf)  return (r > 50'sd65535) ? 16'hFFFF : r[15:0];
    return (r > 50'sd255) ? 16'h00FF : r[15:0];
  endfunction

  function automatic logic [15:0] slice16(logic [AH-1:0] a, logic [3:0] s);
    case (s)
      4'd0: return a[15:0];
      4'd1: return a[31:16];
      4'd2: return a[47:32];
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [7:0] slice8(logic [AB-1:0] a, logic [3:0] s);
    case (s)
      4'd0: return a[7:0];
      4'd1: return a[15:8];
      4'd2: return a[23:16];
      default: return 8'd0;
    endcase
  endfunction

  always_comb begin
    logic [15:0] sh;
    logic [7:0]  sb;
    logic        bad;
    logic [15:0] rv;
    acc_d = acc_q;
    res_d = res_q;
    err_d = err_q;
    sh    = '0;
    sb    = '0;
    rv    = '0;
    bad   = (code > 4'd5) || (!half && !code[0]);
    case (cmd)
      C_ACC: begin
        if (half) begin
          for (int i = 0; i < NH; i++)
            acc_d[i*AH +: AH] = hstep(acc_q[i*AH +: AH], opa[i*16 +: 16],
                                      bcast ? opb[15:0] : opb[i*16 +: 16], code);
        end else begin
          for (int j = 0; j < NB; j++)
            acc_d[j*AB +: AB] = bstep(acc_q[j*AB +: AB], opa[j*8 +: 8],
                                      bcast ? opb[7:0] : opb[j*8 +: 8], code);
        end
      end
      C_RD: begin
        res_d = '0;
        err_d = 1'b0;
        if (half) begin
          for (int i = 0; i < NH; i++)
            res_d[i*16 +: 16] = slice16(acc_q[i*AH +: AH], code);
        end else begin
          for (int j = 0; j < NB; j++)
            res_d[j*8 +: 8] = slice8(acc_q[j*AB +: AB], code);
        end
      end
      C_WLO: begin
        if (half) begin
          for (int i = 0; i < NH; i++)
            acc_d[i*AH +: AH] = {{16{opa[i*16+15]}}, opa[i*16 +: 16], opb[i*16 +: 16]};
        end else begin
          for (int j = 0; j < NB; j++)
            acc_d[j*AB +: AB] = {{8{opa[j*8+7]}}, opa[j*8 +: 8], opb[j*8 +: 8]};
        end
      end
      C_WHI: begin
        if (half) begin
          for (int i = 0; i < NH; i++)
            acc_d[i*AH+32 +: 16] = opa[i*16 +: 16];
        end else begin
          for (int j = 0; j < NB; j++)
            acc_d[j*AB+16 +: 8] = opa[j*8 +: 8];
        end
      end
      C_RND: begin
        res_d = '0;
        err_d = bad;
        if (!bad) begin
          if (half) begin
            for (int i = 0; i < NH; i++) begin
              sh = bcast ? opb[15:0] : opb[i*16 +: 16];
              if (sh[15]) err_d = 1'b1;
              else res_d[i*16 +: 16] = rnd(acc_q[i*AH +: AH], 1'b1,
                                           (sh > 16'd63) ? 7'd64 : sh[6:0], code[2:0]);
            end
          end else begin
            for (int j = 0; j < NB; j++) begin
              sb = bcast ? opb[7:0] : opb[j*8 +: 8];
              rv = rnd({{(AH-AB){1'b0}}, acc_q[j*AB +: AB]}, 1'b0,
                       (sb > 8'd63) ? 7'd64 : sb[6:0], code[2:0]);
              res_d[j*8 +: 8] = rv[7:0];
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
      err_q <= err_d;
    end
  end

  assign res = res_q;
  assign err = err_q;
endmodule

// File: rtl/lane_acc_round_chk.sv
module lane_acc_round_chk #(
  parameter int NB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      cmd,
  input logic [3:0]      code,
  input logic            half,
  input logic            bcast,
  input logic [15:0]     opb_lo,
  input logic [NB*8-1:0] res,
  input logic            err
);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'd2 && cmd != 3'd5) |=> ($stable(res) && $stable(err)));

  p_read_clears_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |=> !err);

  p_read_bad_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 && code > 4'd2) |=> (res == '0));

  p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && (code > 4'd5 || (!half && !code[0]))) |=> (res == '0 && err));

  p_neg_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && half && bcast && opb_lo[15]) |=> (res == '0 && err));
endmodule

bind lane_acc_round lane_acc_round_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .code(code), .half(half),
  .bcast(bcast), .opb_lo(opb[15:0]), .res(res), .err(err)
);

// File: tb/tb_lane_acc_round.sv
module tb_lane_acc_round;
  localparam int NB = 8;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd;
  logic [3:0]    code;
  logic          half;
  logic          bcast;
  logic [DW-1:0] opa, opb;
  logic [DW-1:0] res;
  logic          err;

  always #2 clk = ~clk;

  lane_acc_round #(.NB(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .code(code), .half(half),
    .bcast(bcast), .opa(opa), .opb(opb), .res(res), .err(err)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [191:0] macc;
  logic [63:0]  mres;
  logic         merr;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint sx(longint v, int w);
    longint mk = (longint'(1) << w) - 1;
    longint sb = longint'(1) << (w - 1);
    v = v & mk;
    return (v ^ sb) - sb;
  endfunction

  function automatic longint lane_get(logic [191:0] m, bit hf, int k);
    if (hf) return sx(longint'(m[k*48 +: 48]), 48);
    return sx(longint'(m[k*24 +: 24]), 24);
  endfunction

  function automatic longint elem(logic [63:0] v, bit hf, int k);
    if (hf) return sx(longint'(v[k*16 +: 16]), 16);
    return longint'(v[k*8 +: 8]);
  endfunction

  function automatic longint m_acc(longint a, longint x, longint y, int op, bit hf);
    case (op)
      0: return a + x + y;
      1: return x + y;
      2: return a + x * y;
      3: return x * y;
      4: return a - x * y;
      5: return -(x * y);
      6: return a + x - y;
      7: return x - y;
      8: return hf ? a : a + ((x > y) ? x - y : y - x);
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] m_round(longint a, bit hf, int s, int m);
    longint v, t, low, hv, r;
    int w = hf ? 48 : 24;
    bit sg = (m == 0 || m == 2 || m == 4);
    bit inc;
    if (m == 0 && s > 48) return 16'd0;
    if ((m == 2 || m == 4) && s >= 48) return 16'd0;
    if (!sg && s > w) return 16'd0;
    v = sg ? a : (a & ((longint'(1) << w) - 1));
    if (s == 0) begin
      t = v; low = 0; hv = 1;
    end else begin
      t = v >>> s;
      low = v & ((longint'(1) << s) - 1);
      hv = longint'(1) << (s - 1);
    end
    case (m)
      0: inc = (v >= 0) ? (low >= hv) : (low > hv);
      1: inc = (low >= hv);
      2, 3: inc = (low > hv) || (low == hv && t[0]);
      default: inc = 0;
    endcase
    r = t + longint'(inc);
    if (sg) begin
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
    end else begin
      if (r > (hf ? 65535 : 255)) r = hf ? 65535 : 255;
    end
    return r[15:0];
  endfunction

  task automatic step(string tag, logic [2:0] c, logic [3:0] cd, bit hf, bit bc,
                      logic [63:0] a, logic [63:0] b);
    int n = hf ? 4 : 8;
    cmd = c; code = cd; half = hf; bcast = bc; opa = a; opb = b;
    case (c)
      3'd1: for (int k = 0; k < n; k++) begin
        longint nv = m_acc(lane_get(macc, hf, k), elem(a, hf, k),
                           elem(b, hf, bc ? 0 : k), int'(cd), hf);
        if (hf) macc[k*48 +: 48] = nv[47:0];
        else    macc[k*24 +: 24] = nv[23:0];
      end
      3'd2: begin
        mres = '0; merr = 0;
        if (cd < 3) for (int k = 0; k < n; k++) begin
          if (hf) mres[k*16 +: 16] = macc[k*48 + cd*16 +: 16];
          else    mres[k*8 +: 8]   = macc[k*24 + cd*8 +: 8];
        end
      end
      3'd3: for (int k = 0; k < n; k++) begin
        if (hf) macc[k*48 +: 48] = {{16{a[k*16+15]}}, a[k*16 +: 16], b[k*16 +: 16]};
        else    macc[k*24 +: 24] = {{8{a[k*8+7]}}, a[k*8 +: 8], b[k*8 +: 8]};
      end
      3'd4: for (int k = 0; k < n; k++) begin
        if (hf) macc[k*48+32 +: 16] = a[k*16 +: 16];
        else    macc[k*24+16 +: 8]  = a[k*8 +: 8];
      end
      3'd5: begin
        mres = '0; merr = 0;
        if (cd > 5 || (!hf && (cd == 0 || cd == 2 || cd == 4))) merr = 1;
        else for (int k = 0; k < n; k++) begin
          int s = int'(elem(b, hf, bc ? 0 : k));
          logic [15:0] rv;
          if (hf && s < 0) merr = 1;
          else begin
            rv = m_round(lane_get(macc, hf, k), hf, s, int'(cd));
            if (hf) mres[k*16 +: 16] = rv;
            else    mres[k*8 +: 8]   = rv[7:0];
          end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    chk({tag, " res"}, res, mres);
    chk({tag, " err"}, {63'b0, err}, {63'b0, merr});
  endtask

  function automatic logic [63:0] rshift(bit hf);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) begin
      int p = $urandom % 8;
      int s = (p < 3) ? ($urandom % 6) : (p < 5) ? (22 + $urandom % 5) :
              (p < 7) ? (45 + $urandom % 6) : ($urandom % 256);
      if (hf) begin
        if (k < 4) v[k*16 +: 16] = ($urandom % 16 == 0) ? 16'(16'h8000 | s) : 16'(s);
      end else v[k*8 +: 8] = 8'(s);
    end
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    macc = '0; mres = '0; merr = 0;
    rst_n = 0; cmd = 0; code = 0; half = 0; bcast = 0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset res", res, 64'd0);
    chk("R1 reset err", {63'b0, err}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 3; s++) step("R1 read after reset", 3'd2, 4'(s), 1, 0, '0, '0);

    step("R6 write-low half", 3'd3, 0, 1, 0, {4{16'h8001}}, {4{16'h1234}});
    step("R6 read low", 3'd2, 0, 1, 0, '0, '0);
    chk("R6 low slice literal", res, {4{16'h1234}});
    step("R6 read top", 3'd2, 2, 1, 0, '0, '0);
    chk("R6 sign fill literal", res, {4{16'hFFFF}});
    step("R6 write-high half", 3'd4, 0, 1, 0, {4{16'h00A5}}, '0);
    step("R6 read top after high", 3'd2, 2, 1, 0, '0, '0);
    chk("R6 top slice literal", res, {4{16'h00A5}});
    step("R5 read slice 3", 3'd2, 3, 1, 0, '0, '0);
    step("R13 byte view of halfword data", 3'd2, 1, 0, 0, '0, '0);

    step("R7 set +5", 3'd3, 0, 1, 0, '0, {4{16'h0005}});
    step("R7 nearest-away +2.5", 3'd5, 0, 1, 1, '0, 64'd1);
    chk("R7 away literal", res, {4{16'h0003}});
    step("R7 nearest-even +2.5", 3'd5, 2, 1, 1, '0, 64'd1);
    chk("R7 even literal", res, {4{16'h0002}});
    step("R7 nearest-even unsigned", 3'd5, 3, 1, 1, '0, 64'd1);
    step("R7 set -5", 3'd3, 0, 1, 0, {4{16'hFFFF}}, {4{16'hFFFB}});
    step("R7 away signed -2.5", 3'd5, 0, 1, 1, '0, 64'd1);
    chk("R7 away negative literal", res, {4{16'hFFFD}});
    step("R7 even signed -2.5", 3'd5, 2, 1, 1, '0, 64'd1);
    chk("R7 even negative literal", res, {4{16'hFFFE}});
    step("R7 truncate signed -2.5", 3'd5, 4, 1, 1, '0, 64'd1);

    step("R8 set 2^32", 3'd3, 0, 1, 0, '0, '0);
    step("R8 set 2^32 high", 3'd4, 0, 1, 0, {4{16'h0001}}, '0);
    step("R8 signed high sat", 3'd5, 4, 1, 1, '0, 64'd0);
    chk("R8 signed max literal", res, {4{16'h7FFF}});
    step("R8 unsigned sat", 3'd5, 5, 1, 1, '0, 64'd0);
    chk("R8 unsigned max literal", res, {4{16'hFFFF}});
    step("R8 set negative", 3'd4, 0, 1, 0, {4{16'h8000}}, '0);
    step("R8 signed low sat", 3'd5, 4, 1, 1, '0, 64'd0);
    chk("R8 signed min literal", res, {4{16'h8000}});

    step("R9 unsigned away at 48", 3'd5, 1, 1, 1, '0, 64'd48);
    chk("R9 top bit literal", res, {4{16'h0001}});
    step("R9 unsigned away at 49", 3'd5, 1, 1, 1, '0, 64'd49);
    chk("R9 beyond width literal", res, 64'd0);
    step("R9 even signed at 47", 3'd5, 2, 1, 1, '0, 64'd47);
    step("R9 even signed at 48", 3'd5, 2, 1, 1, '0, 64'd48);
    chk("R9 signed 48 literal", res, 64'd0);
    step("R9 even unsigned at 48", 3'd5, 3, 1, 1, '0, 64'd48);
    step("R9 away signed at 48", 3'd5, 0, 1, 1, '0, 64'd48);
    chk("R9 away signed 48 literal", res, {4{16'hFFFF}});
    step("R9 away signed at 49", 3'd5, 0, 1, 1, '0, 64'd49);

    step("R10 negative lane shift", 3'd5, 1, 1, 0, '0,
         {16'h0001, 16'hFFFF, 16'h0002, 16'h0004});
    chk("R10 lane zero literal", {48'b0, res[47:32]}, 64'd0);
    chk("R10 err literal", {63'b0, err}, 64'd1);
    step("R12 idle holds", 3'd0, 0, 1, 0, '1, '1);
    step("R12 accumulate holds", 3'd1, 0, 1, 0, '1, '1);
    step("R12 code 7 idle", 3'd7, 0, 0, 0, '1, '1);

    step("R2 byte set 3", 3'd3, 0, 0, 0, '0, {8{8'h03}});
    step("R2 byte away 1.5", 3'd5, 1, 0, 1, '0, 64'd1);
    chk("R2 byte away literal", res, {8{8'h02}});
    step("R7 byte even 1.5", 3'd5, 3, 0, 1, '0, 64'd1);
    step("R7 byte truncate 1.5", 3'd5, 5, 0, 1, '0, 64'd1);
    step("R11 byte signed mode", 3'd5, 0, 0, 1, '0, 64'd1);
    chk("R11 literal", res, 64'd0);
    step("R11 mode above 5", 3'd5, 7, 1, 1, '0, 64'd1);
    step("R8 byte set 0x300", 3'd3, 0, 0, 0, {8{8'h03}}, '0);
    step("R8 byte sat", 3'd5, 5, 0, 1, '0, 64'd0);
    chk("R8 byte max literal", res, {8{8'hFF}});
    step("R9 byte set top", 3'd3, 0, 0, 0, '0, '0);
    step("R9 byte set top high", 3'd4, 0, 0, 0, {8{8'h80}}, '0);
    step("R9 byte away at 24", 3'd5, 1, 0, 1, '0, 64'd24);
    chk("R9 byte top bit literal", res, {8{8'h01}});
    step("R9 byte away at 25", 3'd5, 1, 0, 1, '0, 64'd25);
    step("R9 byte truncate at 24", 3'd5, 5, 0, 1, '0, 64'd24);

    step("R4 broadcast product", 3'd1, 3, 1, 1,
         {16'd9, 16'hFFFE, 16'd5, 16'd4}, {16'd7, 16'd7, 16'd7, 16'd3});
    step("R4 read", 3'd2, 0, 1, 0, '0, '0);
    step("R4 byte broadcast", 3'd1, 8, 0, 1, {8'd1, 8'd2, 8'd3, 8'd4, 8'd200, 8'd6, 8'd7, 8'd8}, 64'd5);
    step("R4 byte read", 3'd2, 0, 0, 0, '0, '0);

    for (int it = 0; it < 1500; it++) begin
      int p = $urandom % 10;
      bit hf = $urandom % 2;
      bit bc = ($urandom % 4) == 0;
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (p < 4)       step(hf ? "R3 random accumulate" : "R2 random accumulate",
                            3'd1, 4'($urandom % 11), hf, bc, a, b);
      else if (p < 6)  step("R5 R13 random read", 3'd2, 4'($urandom % 4), hf, 0, a, b);
      else if (p == 6) step("R6 random write-low", 3'd3, 0, hf, 0, a, b);
      else if (p == 7) step("R6 random write-high", 3'd4, 0, hf, 0, a, b);
      else if (p == 8) step("R7 R9 R10 random round", 3'd5, 4'($urandom % 7), hf, bc, a, rshift(hf));
      else             step("R12 random idle", 3'($urandom % 2 ? 0 : 6), 4'($urandom), hf, bc, a, b);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule